// File: doc/BRIEF.md
# Memory-Mapped Bidirectional Parallel Port

This block is a small parallel port that sits inside a processor and is reached through the two lowest locations of its memory map. Location 0 holds a direction register and location 1 holds an output data register. Each implemented pin can be set as an input or an output. A direction bit of 1 makes its pin an output, which drives the matching output register bit. A direction bit of 0 leaves the pin as an input.

Pin levels are captured into a sample register whenever the phase-one strobe is high, which models the first clock phase inside a single-clock design. A read of location 1 returns a value chosen bit by bit. Output bits return the stored output value and input bits return the sampled pin level. Bit position 5 is not built at all. It has no pin and no storage, and it always reads as zero.

Writes use an active-low strobe and reads use an active-high strobe. Read data is registered and appears one clock after the read strobe. All other addresses are ignored.

Top module: `pio_port`

## Requirements
- R1: After a synchronous reset, the direction and output registers are 0, so `pin_oe`, `pin_out` and `bus_rdata` are all 0.
- R2: A clock edge with `bus_wr_n` low and `bus_addr` = 0 loads `bus_wdata` into the direction register. From the next cycle, `pin_oe` shows the new value.
- R3: A clock edge with `bus_wr_n` low and `bus_addr` = 1 loads `bus_wdata` into the output register. From the next cycle, `pin_out` shows the new value.
- R4: A clock edge with `bus_wr_n` high changes no register, whatever the address and data.
- R5: Bit 5 of `pin_oe`, `pin_out` and `bus_rdata` is always 0. Writing a 1 into bit 5 at either address has no visible effect.
- R6: The sample register takes `pin_in` only at a clock edge where `phase1_stb` is high. A pin change with no strobe is not seen by a later read.
- R7: A read of address 1 returns, for each bit, the output register bit when the direction bit is 1 and the sampled pin bit when the direction bit is 0.
- R8: A read of address 0 returns the direction register.
- R9: A write to any address other than 0 or 1 changes neither register. A read of any such address leaves `bus_rdata` unchanged.
- R10: `bus_rdata` is updated at the clock edge where `bus_rd` is high, and it holds its value between reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phase1_stb | input | 1 | Phase-one strobe that enables pin sampling |
| bus_addr | input | ADDR_W | CPU address |
| bus_wdata | input | PORT_W | CPU write data |
| bus_rd | input | 1 | Read strobe, active high |
| bus_wr_n | input | 1 | Write strobe, active low |
| pin_in | input | PORT_W | External pin levels |
| bus_rdata | output | PORT_W | Registered read data |
| pin_out | output | PORT_W | Pin drive values |
| pin_oe | output | PORT_W | Pin output enables |

## Verification
The read multiplexer is tried with all-input, all-output, and split high/low nibble directions. It is also tried with alternating-bit directions against data and pin patterns that differ in every bit, so a wrong select on any bit gives a different value. Some patterns pair an input pin with a 0 output latch, and the reverse, to show whether the pin or the latch feeds a bit. Patterns with bit 5 set in every field show whether the missing bit ever leaks out. Directed cases separate strobed from unstrobed pin sampling, high write strobes, and accesses to other addresses.

// File: rtl/pio_pkg.sv
`timescale 1ns/1ps
package pio_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_DATA = 2'd2
  } pio_sel_e;
endpackage

// File: rtl/pio_addr_decode.sv
`timescale 1ns/1ps
module pio_addr_decode
  import pio_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DIR_ADDR  = 0,
  parameter int DATA_ADDR = 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr_n,
  output pio_sel_e          sel,
  output logic              we_dir,
  output logic              we_dat,
  output logic              rd_hit
);
  localparam logic [ADDR_W-1:0] DIR_A  = ADDR_W'(DIR_ADDR);
  localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_ADDR);

  always_comb begin
    if (addr == DIR_A)       sel = SEL_DIR;
    else if (addr == DATA_A) sel = SEL_DATA;
    else                     sel = SEL_NONE;
  end

  assign we_dir = !wr_n && (sel == SEL_DIR);
  assign we_dat = !wr_n && (sel == SEL_DATA);
  assign rd_hit = rd && (sel != SEL_NONE);
endmodule

// File: rtl/pio_bit_cell.sv
`timescale 1ns/1ps
module pio_bit_cell #(
  parameter bit PRESENT = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic we_dir,
  input  logic we_dat,
  input  logic wbit,
  input  logic phase_stb,
  input  logic pin,
  output logic dir_o,
  output logic dat_o,
  output logic smp_o
);
  generate
    if (PRESENT) begin : g_bit
      logic dir_q, dat_q, smp_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          dir_q <= 1'b0;
          dat_q <= 1'b0;
          smp_q <= 1'b0;
        end else begin
          if (we_dir)    dir_q <= wbit;
          if (we_dat)    dat_q <= wbit;
          if (phase_stb) smp_q <= pin;
        end
      end
      assign dir_o = dir_q;
      assign dat_o = dat_q;
      assign smp_o = smp_q;
    end else begin : g_absent
      logic unused_bits;
      assign unused_bits = ^{clk, rst, we_dir, we_dat, wbit, phase_stb, pin};
      assign dir_o = 1'b0;
      assign dat_o = 1'b0;
      assign smp_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/pio_read_mux.sv
`timescale 1ns/1ps
module pio_read_mux
  import pio_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input  pio_sel_e          sel,
  input  logic [PORT_W-1:0] dir,
  input  logic [PORT_W-1:0] dat,
  input  logic [PORT_W-1:0] smp,
  output logic [PORT_W-1:0] rd_val
);
  logic [PORT_W-1:0] data_view;

  genvar gi;
  generate
    for (gi = 0; gi < PORT_W; gi++) begin : g_sel
      assign data_view[gi] = dir[gi] ? dat[gi] : smp[gi];
    end
  endgenerate

  always_comb begin
    unique case (sel)
      SEL_DIR:  rd_val = dir;
      SEL_DATA: rd_val = data_view;
      default:  rd_val = '0;
    endcase
  end
endmodule

// File: rtl/pio_port.sv
`timescale 1ns/1ps
module pio_port
  import pio_pkg::*;
#(
  parameter int                 ADDR_W      = 16,
  parameter int                 PORT_W      = 8,
  parameter logic [PORT_W-1:0]  ABSENT_MASK = 8'h20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              phase1_stb,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PORT_W-1:0] bus_wdata,
  input  logic              bus_rd,
  input  logic              bus_wr_n,
  input  logic [PORT_W-1:0] pin_in,
  output logic [PORT_W-1:0] bus_rdata,
  output logic [PORT_W-1:0] pin_out,
  output logic [PORT_W-1:0] pin_oe
);
  localparam logic [PORT_W-1:0] LIVE_MASK = ~ABSENT_MASK;

  pio_sel_e          sel;
  logic              we_dir, we_dat, rd_hit;
  logic [PORT_W-1:0] dir_v, dat_v, smp_v, rd_val;
  logic [PORT_W-1:0] rdata_q;

  pio_addr_decode #(.ADDR_W(ADDR_W), .DIR_ADDR(0), .DATA_ADDR(1)) u_dec (
    .addr(bus_addr), .rd(bus_rd), .wr_n(bus_wr_n),
    .sel(sel), .we_dir(we_dir), .we_dat(we_dat), .rd_hit(rd_hit)
  );

  genvar gi;
  generate
    for (gi = 0; gi < PORT_W; gi++) begin : g_cell
      pio_bit_cell #(.PRESENT(!ABSENT_MASK[gi])) u_cell (
        .clk(clk), .rst(rst), .we_dir(we_dir), .we_dat(we_dat),
        .wbit(bus_wdata[gi]), .phase_stb(phase1_stb), .pin(pin_in[gi]),
        .dir_o(dir_v[gi]), .dat_o(dat_v[gi]), .smp_o(smp_v[gi])
      );
    end
  endgenerate

  pio_read_mux #(.PORT_W(PORT_W)) u_mux (
    .sel(sel), .dir(dir_v), .dat(dat_v), .smp(smp_v), .rd_val(rd_val)
  );

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (rd_hit) rdata_q <= rd_val;
  end

  assign bus_rdata = rdata_q;
  assign pin_out   = dat_v;
  assign pin_oe    = dir_v;

  // R2
  dir_write_chk: assert property (@(posedge clk) disable iff (rst)
    (!bus_wr_n && bus_addr == '0) |=> (pin_oe == ($past(bus_wdata) & LIVE_MASK)));

  // R3
  dat_write_chk: assert property (@(posedge clk) disable iff (rst)
    (!bus_wr_n && bus_addr == ADDR_W'(1)) |=> (pin_out == ($past(bus_wdata) & LIVE_MASK)));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    bus_wr_n |=> ($stable(pin_oe) && $stable(pin_out)));

  // R5
  absent_bit_chk: assert property (@(posedge clk) disable iff (rst)
    ((bus_rdata & ABSENT_MASK) == '0) && ((pin_oe & ABSENT_MASK) == '0)
    && ((pin_out & ABSENT_MASK) == '0));

  // R7
  data_read_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(1)) |=>
      (bus_rdata == (($past(pin_oe) & $past(pin_out)) | (~$past(pin_oe) & $past(smp_v)))));

  // R9
  foreign_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_addr > ADDR_W'(1)) |=> ($stable(pin_oe) && $stable(pin_out) && $stable(bus_rdata)));

  // R10
  read_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/pio_port_bench.sv
`timescale 1ns/1ps
module pio_port_bench;
  localparam int ADDR_W = 16;
  localparam int W      = 8;
  localparam logic [W-1:0] LIVE = 8'hDF;
  localparam int NV = 8;
  // each vector: {direction, output data, pin levels}
  localparam logic [23:0] VEC [NV] = '{
    24'h00_FF_A5, 24'hFF_3C_00, 24'hF0_AA_55, 24'h0F_AA_55,
    24'h55_FF_00, 24'hAA_00_FF, 24'hDF_12_FF, 24'h20_20_20
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic phase1_stb = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [W-1:0] bus_wdata = '0;
  logic bus_rd = 1'b0;
  logic bus_wr_n = 1'b1;
  logic [W-1:0] pin_in = '0;
  logic [W-1:0] bus_rdata, pin_out, pin_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  pio_port u_pio_port (
    .clk(clk), .rst(rst), .phase1_stb(phase1_stb), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_wr_n(bus_wr_n), .pin_in(pin_in),
    .bus_rdata(bus_rdata), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [W-1:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr_n = 1'b0;
    @(negedge clk); bus_wr_n = 1'b1;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic strobe();
    @(negedge clk); phase1_stb = 1'b1;
    @(negedge clk); phase1_stb = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 oe", pin_oe, 8'h00);
    check("R1 out", pin_out, 8'h00);
    check("R1 rdata", bus_rdata, 8'h00);

    // vector table: R2 R3 R7 R8 R5
    for (int i = 0; i < NV; i++) begin
      logic [W-1:0] d, o, p;
      d = VEC[i][23:16]; o = VEC[i][15:8]; p = VEC[i][7:0];
      wr(16'd0, d);
      wr(16'd1, o);
      pin_in = p;
      strobe();
      check("R2 oe", pin_oe, d & LIVE);
      check("R3 out", pin_out, o & LIVE);
      rd(16'd1);
      check("R7 data read", bus_rdata, ((d & o) | (~d & p)) & LIVE);
      rd(16'd0);
      check("R8 dir read", bus_rdata, d & LIVE);
    end

    // R4 high write strobe does nothing
    wr(16'd0, 8'h00);
    wr(16'd1, 8'h00);
    @(negedge clk); bus_addr = 16'd0; bus_wdata = 8'hFF; bus_wr_n = 1'b1;
    @(negedge clk); bus_addr = 16'd1;
    @(negedge clk);
    check("R4 oe", pin_oe, 8'h00);
    check("R4 out", pin_out, 8'h00);

    // R5 writing bit 5 only
    wr(16'd0, 8'h20);
    wr(16'd1, 8'h20);
    check("R5 oe", pin_oe, 8'h00);
    check("R5 out", pin_out, 8'h00);
    pin_in = 8'h20; strobe();
    rd(16'd1);
    check("R5 data read", bus_rdata, 8'h00);

    // R6 no strobe -> old sample
    pin_in = 8'h0F; strobe();
    pin_in = 8'hF0;
    repeat (2) @(negedge clk);
    rd(16'd1);
    check("R6 unstrobed", bus_rdata, 8'h0F);
    strobe();
    rd(16'd1);
    check("R6 strobed", bus_rdata, 8'hD0);

    // R9 foreign addresses
    wr(16'd0, 8'h0C);
    wr(16'd1, 8'h05);
    rd(16'd0);
    held = bus_rdata;
    wr(16'd2, 8'hFF);
    wr(16'hFFFF, 8'hFF);
    check("R9 oe", pin_oe, 8'h0C);
    check("R9 out", pin_out, 8'h05);
    rd(16'd3);
    check("R9 rdata", bus_rdata, held);

    // R10 latency and hold
    @(negedge clk); bus_addr = 16'd1; bus_rd = 1'b1;
    check("R10 before edge", bus_rdata, 8'h0C);
    @(negedge clk); bus_rd = 1'b0;
    check("R10 after edge", bus_rdata, 8'hD4);
    pin_in = 8'h00; strobe();
    repeat (3) @(negedge clk);
    check("R10 hold", bus_rdata, 8'hD4);

    // R1 reset again clears registers
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 re-reset oe", pin_oe, 8'h00);
    check("R1 re-reset rdata", bus_rdata, 8'h00);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule